// File: doc/BRIEF.md
# Sound CPU I/O Page Decoder

This block sits between a sound processor's byte-wide bus and the devices that share its 64 KB address space. It watches the sixteen addresses 0x00F0 to 0x00FF, which hold the control byte, an indirect window onto the DSP register file, the timer period writes and the timer counter reads. Every other address goes to the RAM port. All decoding is combinational, so read data and every outgoing strobe appear in the same cycle as the CPU access. The only state in the block is the control byte and the DSP register index.

The top 64 bytes of memory, 0xFFC0 to 0xFFFF, can be covered by a boot-ROM overlay. Bit 7 of the control byte at 0x00F1 turns the overlay on, and it is on after reset. While it is on, reads in that range come from the ROM port. Writes to that range always reach the RAM underneath, so the RAM keeps a shadow copy that becomes visible once the overlay is turned off. The external ROM is expected to end with the bytes 0xC0 and 0xFF, a reset vector that points at the ROM's own first byte.

The DSP is reached in two steps. First the CPU writes a register index to 0x00F2. Then it reads or writes 0x00F3. Reads always use the low seven bits of the index. A write is dropped when index bit 7 is set.

Top module: `sndio_page_dec`

## Requirements
- R1: After reset the overlay is enabled, the timer enables `tmr_enable` are 0, and the DSP index reads back as 0x00.
- R2: A write to 0x00F2 stores the byte as the DSP index. A read of 0x00F2 returns the stored index. Neither access asserts `ram_we` or `ram_re`.
- R3: A read of 0x00F3 asserts `dsp_re` and returns `dsp_rdata` on `cpu_rdata`. `dsp_addr` always equals index bits 6:0.
- R4: A write to 0x00F3 asserts `dsp_we`, with `dsp_wdata` equal to `cpu_wdata`, only when index bit 7 is 0. When index bit 7 is 1, no strobe leaves the block.
- R5: A write to 0x00F1 takes effect at the next clock edge. Data bit 7 becomes the overlay enable and data bits 2:0 drive `tmr_enable[2:0]`. A read of 0x00F1 returns 0x00.
- R6: A read in 0xFFC0 to 0xFFFF while the overlay is on returns `rom_rdata`, asserts `rom_re` and does not assert `ram_re`. While the overlay is off, it returns `ram_rdata` and asserts `ram_re`. `rom_addr` equals address bits 5:0.
- R7: A write in 0xFFC0 to 0xFFFF asserts `ram_we` whatever the overlay setting.
- R8: A write to 0x00FA, 0x00FB or 0x00FC asserts `tmr_period_we` bit 0, 1 or 2 respectively, and no other strobe. Reads there return 0x00.
- R9: A read of 0x00FD, 0x00FE or 0x00FF returns timer counter 0, 1 or 2 zero-extended and asserts `tmr_cnt_rd` for that timer. Counter n sits in `tmr_cnt[4n+3:4n]`. A write there asserts `tmr_cnt_clr` for that timer.
- R10: Addresses outside the control page, and outside the ROM range when the overlay is on, pass straight to RAM: `ram_re` follows `cpu_rd`, `ram_we` follows `cpu_wr`, and `cpu_rdata` equals `ram_rdata`. This includes 0x00F4 to 0x00F9.
- R11: A write to 0x00F0 has no effect and asserts no strobe. A read of 0x00F0 returns 0x00.
- R12: `ram_addr` always equals `cpu_addr` and `ram_wdata` always equals `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data back to the CPU |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | RAM read data |
| rom_addr | output | 6 | Boot-ROM byte offset |
| rom_re | output | 1 | Boot-ROM read strobe |
| rom_rdata | input | 8 | Boot-ROM read data |
| dsp_addr | output | 7 | DSP register number |
| dsp_wdata | output | 8 | DSP write data |
| dsp_re | output | 1 | DSP read strobe |
| dsp_we | output | 1 | DSP write strobe |
| dsp_rdata | input | 8 | DSP read data |
| tmr_enable | output | 3 | Timer run enables |
| tmr_period_we | output | 3 | Per-timer period write strobes |
| tmr_cnt_rd | output | 3 | Per-timer counter read strobes |
| tmr_cnt_clr | output | 3 | Per-timer counter clear strobes |
| tmr_cnt | input | 12 | Three 4-bit timer counter values |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together, and that `cpu_addr` and `cpu_wdata` are stable for the whole cycle in which a strobe is high. Several checks also depend on the index and overlay state that the checker rebuilds from control-page writes. That rebuilt state is only correct when every change to it arrives over the CPU bus. The stimulus drives one access per cycle, changes inputs only on the falling edge, and waits until the synchronized reset has been released before the first access.

// File: rtl/sndio_pkg.sv
package sndio_pkg;
  typedef enum logic [2:0] {
    RG_RAM,
    RG_ROM,
    RG_TEST,
    RG_CTRL,
    RG_IDX,
    RG_DATA,
    RG_PERIOD,
    RG_COUNT
  } region_e;
endpackage

// File: rtl/sndio_rst_sync.sv
module sndio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/sndio_map.sv
module sndio_map
  import sndio_pkg::*;
#(
  parameter int AW     = 16,
  parameter int ROM_AW = 6,
  parameter int NTMR   = 3,
  parameter int TSW    = 2
) (
  input  logic [AW-1:0]  addr,
  output region_e        rgn,
  output logic [TSW-1:0] tsel
);
  localparam logic [AW-5:0] PAGE_ID  = (AW-4)'(15);
  localparam int            CNT_BASE = 16 - NTMR;
  localparam int            PER_BASE = 16 - 2 * NTMR;

  logic [3:0] lo;
  assign lo = addr[3:0];

  always_comb begin
    rgn  = RG_RAM;
    tsel = '0;
    if (addr[AW-1:4] == PAGE_ID) begin
      case (lo)
        4'h0:    rgn = RG_TEST;
        4'h1:    rgn = RG_CTRL;
        4'h2:    rgn = RG_IDX;
        4'h3:    rgn = RG_DATA;
        default: begin
          if (lo >= 4'(CNT_BASE)) begin
            rgn  = RG_COUNT;
            tsel = TSW'(lo - 4'(CNT_BASE));
          end else if (lo >= 4'(PER_BASE)) begin
            rgn  = RG_PERIOD;
            tsel = TSW'(lo - 4'(PER_BASE));
          end
        end
      endcase
    end else if (&addr[AW-1:ROM_AW]) begin
      rgn = RG_ROM;
    end
  end
endmodule

// File: rtl/sndio_regs.sv
module sndio_regs
  import sndio_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NTMR = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  region_e         rgn,
  input  logic [DW-1:0]   wdata,
  output logic            ovl_q,
  output logic [NTMR-1:0] ten_q,
  output logic [DW-1:0]   idx_q
);
  logic            ctrl_en, idx_en;
  logic            ovl_d;
  logic [NTMR-1:0] ten_d;
  logic [DW-1:0]   idx_d;

  always_comb begin
    ctrl_en = wr && (rgn == RG_CTRL);
    idx_en  = wr && (rgn == RG_IDX);
    ovl_d   = wdata[DW-1];
    ten_d   = wdata[NTMR-1:0];
    idx_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q <= 1'b1;
      ten_q <= '0;
    end else if (ctrl_en) begin
      ovl_q <= ovl_d;
      ten_q <= ten_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/sndio_rdmux.sv
module sndio_rdmux
  import sndio_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NTMR = 3,
  parameter int CW   = 4,
  parameter int TSW  = 2
) (
  input  region_e            rgn,
  input  logic [TSW-1:0]     tsel,
  input  logic               ovl,
  input  logic [DW-1:0]      idx,
  input  logic [DW-1:0]      ram_rdata,
  input  logic [DW-1:0]      rom_rdata,
  input  logic [DW-1:0]      dsp_rdata,
  input  logic [NTMR*CW-1:0] tmr_cnt,
  output logic [DW-1:0]      rdata
);
  logic [CW-1:0] cnt_sel;

  always_comb begin
    cnt_sel = '0;
    for (int i = 0; i < NTMR; i++) begin
      if (tsel == TSW'(i)) cnt_sel = tmr_cnt[i*CW +: CW];
    end
  end

  always_comb begin
    case (rgn)
      RG_ROM:   rdata = ovl ? rom_rdata : ram_rdata;
      RG_IDX:   rdata = idx;
      RG_DATA:  rdata = dsp_rdata;
      RG_COUNT: rdata = DW'(cnt_sel);
      RG_TEST, RG_CTRL, RG_PERIOD: rdata = '0;
      default:  rdata = ram_rdata;
    endcase
  end
endmodule

// File: rtl/sndio_page_dec.sv
module sndio_page_dec
  import sndio_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int ROM_AW = 6,
  parameter int NTMR   = 3,
  parameter int CW     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  output logic [DW-1:0]      cpu_rdata,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      ram_wdata,
  output logic               ram_re,
  output logic               ram_we,
  input  logic [DW-1:0]      ram_rdata,
  output logic [ROM_AW-1:0]  rom_addr,
  output logic               rom_re,
  input  logic [DW-1:0]      rom_rdata,
  output logic [DW-2:0]      dsp_addr,
  output logic [DW-1:0]      dsp_wdata,
  output logic               dsp_re,
  output logic               dsp_we,
  input  logic [DW-1:0]      dsp_rdata,
  output logic [NTMR-1:0]    tmr_enable,
  output logic [NTMR-1:0]    tmr_period_we,
  output logic [NTMR-1:0]    tmr_cnt_rd,
  output logic [NTMR-1:0]    tmr_cnt_clr,
  input  logic [NTMR*CW-1:0] tmr_cnt
);
  localparam int TSW = (NTMR > 1) ? $clog2(NTMR) : 1;

  logic           rst_q_n;
  region_e        rgn;
  logic [TSW-1:0] tsel;
  logic           ovl_q;
  logic [DW-1:0]  idx_q;

  sndio_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  sndio_map #(.AW(AW), .ROM_AW(ROM_AW), .NTMR(NTMR), .TSW(TSW)) u_map (
    .addr (cpu_addr),
    .rgn  (rgn),
    .tsel (tsel)
  );

  sndio_regs #(.DW(DW), .NTMR(NTMR)) u_regs (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr    (cpu_wr),
    .rgn   (rgn),
    .wdata (cpu_wdata),
    .ovl_q (ovl_q),
    .ten_q (tmr_enable),
    .idx_q (idx_q)
  );

  sndio_rdmux #(.DW(DW), .NTMR(NTMR), .CW(CW), .TSW(TSW)) u_rdmux (
    .rgn       (rgn),
    .tsel      (tsel),
    .ovl       (ovl_q),
    .idx       (idx_q),
    .ram_rdata (ram_rdata),
    .rom_rdata (rom_rdata),
    .dsp_rdata (dsp_rdata),
    .tmr_cnt   (tmr_cnt),
    .rdata     (cpu_rdata)
  );

  always_comb begin
    ram_addr  = cpu_addr;
    ram_wdata = cpu_wdata;
    ram_re    = cpu_rd && ((rgn == RG_RAM) || ((rgn == RG_ROM) && !ovl_q));
    ram_we    = cpu_wr && ((rgn == RG_RAM) || (rgn == RG_ROM));
    rom_addr  = cpu_addr[ROM_AW-1:0];
    rom_re    = cpu_rd && (rgn == RG_ROM) && ovl_q;
    dsp_addr  = idx_q[DW-2:0];
    dsp_wdata = cpu_wdata;
    dsp_re    = cpu_rd && (rgn == RG_DATA);
    dsp_we    = cpu_wr && (rgn == RG_DATA) && !idx_q[DW-1];
  end

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    logic hit;
    assign hit               = (tsel == TSW'(g));
    assign tmr_period_we[g]  = cpu_wr && (rgn == RG_PERIOD) && hit;
    assign tmr_cnt_rd[g]     = cpu_rd && (rgn == RG_COUNT) && hit;
    assign tmr_cnt_clr[g]    = cpu_wr && (rgn == RG_COUNT) && hit;
  end
endmodule

// File: rtl/sndio_page_dec_chk.sv
module sndio_page_dec_chk #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int ROM_AW = 6,
  parameter int NTMR   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   cpu_addr,
  input logic [DW-1:0]   cpu_wdata,
  input logic            cpu_rd,
  input logic            cpu_wr,
  input logic [DW-1:0]   cpu_rdata,
  input logic            ram_we,
  input logic [DW-1:0]   rom_rdata,
  input logic [DW-2:0]   dsp_addr,
  input logic            dsp_re,
  input logic            dsp_we,
  input logic [NTMR-1:0] tmr_enable,
  input logic [NTMR-1:0] tmr_period_we
);
  localparam logic [AW-1:0] A_CTRL = AW'(16'h00F1);
  localparam logic [AW-1:0] A_IDX  = AW'(16'h00F2);
  localparam logic [AW-1:0] A_DATA = AW'(16'h00F3);

  logic          seen_ovl;
  logic [DW-1:0] seen_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ovl <= 1'b1;
      seen_idx <= '0;
    end else if (cpu_wr) begin
      if (cpu_addr == A_CTRL) seen_ovl <= cpu_wdata[DW-1];
      if (cpu_addr == A_IDX)  seen_idx <= cpu_wdata;
    end
  end

  p_dsp_raddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_re |-> (dsp_addr == seen_idx[DW-2:0]));

  p_dsp_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_we |-> (cpu_wr && (cpu_addr == A_DATA) && !seen_idx[DW-1]));

  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (cpu_addr == A_CTRL)) |=> (tmr_enable == $past(cpu_wdata[NTMR-1:0])));

  p_overlay_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && (&cpu_addr[AW-1:ROM_AW]) && seen_ovl) |-> (cpu_rdata == rom_rdata));

  p_shadow_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (&cpu_addr[AW-1:ROM_AW])) |-> ram_we);

  p_period_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_period_we));
endmodule

bind sndio_page_dec sndio_page_dec_chk #(
  .AW(AW), .DW(DW), .ROM_AW(ROM_AW), .NTMR(NTMR)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .cpu_addr      (cpu_addr),
  .cpu_wdata     (cpu_wdata),
  .cpu_rd        (cpu_rd),
  .cpu_wr        (cpu_wr),
  .cpu_rdata     (cpu_rdata),
  .ram_we        (ram_we),
  .rom_rdata     (rom_rdata),
  .dsp_addr      (dsp_addr),
  .dsp_re        (dsp_re),
  .dsp_we        (dsp_we),
  .tmr_enable    (tmr_enable),
  .tmr_period_we (tmr_period_we)
);

// File: tb/sndio_page_dec_tb_top.sv
module sndio_page_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ram_re, ram_we;
  logic [7:0]  ram_rdata = '0;
  logic [5:0]  rom_addr;
  logic        rom_re;
  logic [7:0]  rom_rdata = '0;
  logic [6:0]  dsp_addr;
  logic [7:0]  dsp_wdata;
  logic        dsp_re, dsp_we;
  logic [7:0]  dsp_rdata = '0;
  logic [2:0]  tmr_enable, tmr_period_we, tmr_cnt_rd, tmr_cnt_clr;
  logic [11:0] tmr_cnt = 12'h95C;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference state, kept behaviourally
  int m_ovl = 1;
  int m_ten = 0;
  int m_idx = 0;

  always #5 clk = ~clk;

  sndio_page_dec dut_i (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic op(input string tag, input bit rd, input bit wr, input int addr, input int data);
    int lo, ex_rd, ex_rre, ex_rwe, ex_dre, ex_dwe, ex_mre, ex_per, ex_crd, ex_clr;
    bit page, rom, plain;
    @(negedge clk);
    cpu_addr  = 16'(addr);
    cpu_wdata = 8'(data);
    cpu_rd    = rd;
    cpu_wr    = wr;
    ram_rdata = 8'(addr + 8'h11);
    rom_rdata = 8'(~addr);
    dsp_rdata = 8'(8'h3C ^ addr);
    #2;
    page  = (addr >= 'h00F0) && (addr <= 'h00FF);
    rom   = (addr >= 'hFFC0);
    lo    = addr % 16;
    plain = (!page && !rom) || (page && lo >= 4 && lo <= 9);
    ex_rd = 'h00;
    if (plain) ex_rd = (addr + 'h11) % 256;
    else if (rom) ex_rd = m_ovl ? ((~addr) & 'hFF) : ((addr + 'h11) % 256);
    else if (lo == 2) ex_rd = m_idx;
    else if (lo == 3) ex_rd = ('h3C ^ addr) & 'hFF;
    else if (lo >= 13) ex_rd = (tmr_cnt >> (4 * (lo - 13))) & 'hF;
    ex_rre = rd && (plain || (rom && !m_ovl));
    ex_rwe = wr && (plain || rom);
    ex_mre = rd && rom && m_ovl;
    ex_dre = rd && page && lo == 3;
    ex_dwe = wr && page && lo == 3 && m_idx < 128;
    ex_per = (wr && page && lo >= 10 && lo <= 12) ? (1 << (lo - 10)) : 0;
    ex_crd = (rd && page && lo >= 13) ? (1 << (lo - 13)) : 0;
    ex_clr = (wr && page && lo >= 13) ? (1 << (lo - 13)) : 0;
    if (rd) chk(tag, "cpu_rdata", cpu_rdata, ex_rd);
    chk(tag, "ram_re", ram_re, ex_rre);
    chk(tag, "ram_we", ram_we, ex_rwe);
    chk(tag, "rom_re", rom_re, ex_mre);
    chk(tag, "rom_addr", rom_addr, addr % 64);
    chk(tag, "dsp_re", dsp_re, ex_dre);
    chk(tag, "dsp_we", dsp_we, ex_dwe);
    chk(tag, "dsp_addr", dsp_addr, m_idx % 128);
    if (ex_dwe) chk(tag, "dsp_wdata", dsp_wdata, data);
    chk(tag, "tmr_period_we", tmr_period_we, ex_per);
    chk(tag, "tmr_cnt_rd", tmr_cnt_rd, ex_crd);
    chk(tag, "tmr_cnt_clr", tmr_cnt_clr, ex_clr);
    chk(tag, "tmr_enable", tmr_enable, m_ten);
    chk("R12", "ram_addr", ram_addr, addr);
    chk("R12", "ram_wdata", ram_wdata, data);
    @(posedge clk);
    #1;
    if (wr && page && lo == 1) begin
      m_ovl = (data >> 7) & 1;
      m_ten = data & 7;
    end
    if (wr && page && lo == 2) m_idx = data & 'hFF;
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    op("R1", 1, 0, 'h00F2, 0);
    op("R1", 1, 0, 'hFFFE, 0);
    op("R1", 0, 0, 'h0000, 0);
    // R2: index storage
    op("R2", 0, 1, 'h00F2, 'h45);
    op("R2", 1, 0, 'h00F2, 0);
    // R3: indirect read
    op("R3", 1, 0, 'h00F3, 0);
    // R4: gated indirect write
    op("R4", 0, 1, 'h00F3, 'h77);
    op("R4", 0, 1, 'h00F2, 'hC5);
    op("R4", 0, 1, 'h00F3, 'h12);
    op("R3", 1, 0, 'h00F3, 0);
    op("R4", 0, 1, 'h00F2, 'h7F);
    op("R4", 0, 1, 'h00F3, 'hA0);
    // R5: control byte
    op("R5", 0, 1, 'h00F1, 'h07);
    op("R5", 1, 0, 'h00F1, 0);
    op("R5", 0, 0, 'h0000, 0);
    // R6: overlay off then on
    op("R6", 1, 0, 'hFFC0, 0);
    op("R7", 0, 1, 'hFFE4, 'h3A);
    op("R5", 0, 1, 'h00F1, 'h82);
    op("R6", 1, 0, 'hFFFF, 0);
    op("R6", 1, 0, 'hFFC1, 0);
    op("R6", 1, 0, 'hFFBF, 0);
    // R7: writes under the overlay reach RAM
    op("R7", 0, 1, 'hFFD0, 'h5E);
    // R8: period strobes
    op("R8", 0, 1, 'h00FA, 'h10);
    op("R8", 0, 1, 'h00FB, 'h20);
    op("R8", 0, 1, 'h00FC, 'h00);
    op("R8", 1, 0, 'h00FB, 0);
    // R9: counters
    op("R9", 1, 0, 'h00FD, 0);
    op("R9", 1, 0, 'h00FE, 0);
    op("R9", 1, 0, 'h00FF, 0);
    op("R9", 0, 1, 'h00FE, 'h99);
    // R10: plain RAM
    op("R10", 1, 0, 'h1234, 0);
    op("R10", 0, 1, 'h00F5, 'h66);
    op("R10", 1, 0, 'h00F8, 0);
    op("R10", 0, 1, 'h0100, 'h01);
    op("R10", 1, 0, 'h00EF, 0);
    op("R10", 1, 0, 'h01F3, 0);
    // R11: test address
    op("R11", 0, 1, 'h00F0, 'hFF);
    op("R11", 1, 0, 'h00F0, 0);
    op("R11", 1, 0, 'h00F2, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule